// File: doc/BRIEF.md
# Three-Phase Non-Overlapping Phase Generator

This block turns one input clock into the switching phases of a chain of switched-capacitor pipeline stages. It divides the input clock by three and steps a one-hot ring through three phases: sample, amplify and hold. Each phase owns one input period of a three-period frame. A guard gap is cut at both ends of every phase. The gaps are timed by a faster reference clock, which also clocks all of the logic, and their width in reference cycles is set by `dead_i`.

The block measures the length of each input period in reference cycles. It uses the most recent measurement to find where the next phase must end. The phases of stage 0 are rotated to give the phase sets of the following stages, so three stages form one repeating group. An extra front-end phase follows the sample phase but drops one reference cycle earlier. This lets the bottom plate open before the top plate in the single-ended-to-differential input sampler.

If the ring is upset out of its one-hot state, every output is held low. The ring then restarts at sample on the next input edge.

Top module: `nonoverlap_phase_gen`

## Requirements
- R1: After `rst_ni` falls, every output is low. All outputs stay low until two rising edges of `clk_in_i` have been detected, that is, until one whole input period has been measured.
- R2: The stage-0 bits of `phase_o` are defined as follows: bit 0 is sample, bit 1 is amplify and bit 2 is hold. They become active in that order, one per input period, and the first phase active after reset is sample. With a steady input half-period of h reference cycles, sample rises every 6·h reference cycles.
- R3: At most one of `phase_o[2:0]` is high in any reference cycle.
- R4: With a steady input period of L reference cycles, each phase is high for L − 2·`dead_i` cycles. Consecutive phases are separated by exactly 2·`dead_i` low cycles, so with `dead_i` = 0 they are back to back.
- R5: `clk_in_i` passes through a two-flop synchroniser and an edge detector. The first output cycle of a new period follows the fourth reference edge, counting from the edge that first samples `clk_in_i` high. Count c = 0 from that cycle. The active phase is high while `dead_i` ≤ c < L − `dead_i`, where L is the previous input period in reference cycles, saturating at 2^CNT_W − 1.
- R6: `fe_phase_o` is high only while the stage-0 sample phase is high. It rises with sample and is high while `dead_i` ≤ c < L − `dead_i` − 1, so it falls one reference cycle before sample.
- R7: Bits 3k, 3k+1 and 3k+2 of `phase_o` are the sample, amplify and hold of stage k. Stage k takes its sample from the hold of stage k−1, its amplify from the sample of stage k−1, and its hold from the amplify of stage k−1.
- R8: If the ring state is not one-hot, all phase outputs and `fe_phase_o` are low. At the next detected input edge the ring becomes sample, and sample is the phase driven in that period.
- R9: Even when the input period shrinks, a stage-0 phase never rises fewer than `dead_i` low cycles after the previous phase fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock; clocks all logic and times the gaps |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_in_i | input | 1 | Input clock to be divided by three, sampled as data |
| dead_i | input | DEAD_W | Guard gap at each phase edge, in reference cycles |
| phase_o | output | 3·STAGES | Phase sets; bits 3k..3k+2 are sample, amplify, hold of stage k |
| fe_phase_o | output | 1 | Front-end sampler phase, early-falling copy of stage-0 sample |

## Verification
The gap property assumes that `dead_i` only changes while reset is held. The model check assumes that `clk_in_i` is low or high for at least a few reference cycles at a time. It also assumes that a period is longer than twice the gap, so that every phase has a non-empty window. The stimulus moves `clk_in_i` only on falling reference edges and loads each new `dead_i` value under reset. It keeps every period above 2·`dead_i` + 1 cycles. It shortens the period once while running, so the shrinking-period case of the gap rule is exercised without breaking these assumptions. One upset is injected in the middle of a sample window, and the restart is then observed at the outputs.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  localparam int PHASES = 3;
  typedef logic [PHASES-1:0] ring_t;
  localparam ring_t RING_SAMPLE = 3'b001;

  // sample -> amplify -> hold -> sample
  function automatic ring_t ring_advance(ring_t r);
    return {r[PHASES-2:0], r[PHASES-1]};
  endfunction
endpackage

// File: rtl/pgen_sync.sv
module pgen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pgen_period.sv
module pgen_period #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lvl_i,
  output logic          edge_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] len_o,
  output logic          ok_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic          prev_q, started_q, ok_q;
  logic [CW-1:0] cnt_q, len_q;

  assign edge_o = lvl_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q    <= 1'b0;
      started_q <= 1'b0;
      ok_q      <= 1'b0;
      cnt_q     <= '0;
      len_q     <= '0;
    end else begin
      prev_q <= lvl_i;
      if (edge_o) begin
        started_q <= 1'b1;
        cnt_q     <= '0;
        if (started_q) begin
          ok_q  <= 1'b1;
          len_q <= (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
        end
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign len_o = len_q;
  assign ok_o  = ok_q;
endmodule

// File: rtl/pgen_ring.sv
module pgen_ring
  import pgen_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  edge_i,
  input  logic  ok_i,
  output ring_t ring_o
);
  ring_t ring_q, ring_d;

  always_comb begin
    ring_d = ring_q;
    if (edge_i) begin
      if (!$onehot(ring_q)) ring_d = RING_SAMPLE;
      else if (ok_i)        ring_d = ring_advance(ring_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ring_q <= RING_SAMPLE;
    else         ring_q <= ring_d;
  end

  assign ring_o = ring_q;
endmodule

// File: rtl/nonoverlap_phase_gen.sv
module nonoverlap_phase_gen
  import pgen_pkg::*;
#(
  parameter int STAGES = 3,
  parameter int DEAD_W = 4,
  parameter int CNT_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic                  clk_ref_i,
  input  logic                  rst_ni,
  input  logic                  clk_in_i,
  input  logic [DEAD_W-1:0]     dead_i,
  output logic [3*STAGES-1:0]   phase_o,
  output logic                  fe_phase_o
);
  localparam logic [CNT_W:0] ONE_X = 1;

  logic             in_lvl, in_edge, meas_ok;
  logic [CNT_W-1:0] cnt, len;
  ring_t            ring_cur;

  pgen_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i(clk_ref_i), .rst_ni(rst_ni), .d_i(clk_in_i), .q_o(in_lvl)
  );

  pgen_period #(.CW(CNT_W)) u_period (
    .clk_i(clk_ref_i), .rst_ni(rst_ni), .lvl_i(in_lvl),
    .edge_o(in_edge), .cnt_o(cnt), .len_o(len), .ok_o(meas_ok)
  );

  pgen_ring u_ring (
    .clk_i(clk_ref_i), .rst_ni(rst_ni), .edge_i(in_edge),
    .ok_i(meas_ok), .ring_o(ring_cur)
  );

  // window test in one extra bit so cnt + dead cannot wrap
  logic [CNT_W:0] c_x, d_x, l_x;
  logic           win, fe_win, ring_ok;
  ring_t          ph0_d, ph0_q;
  logic           fe_d, fe_q;

  assign c_x     = {1'b0, cnt};
  assign d_x     = (CNT_W+1)'(dead_i);
  assign l_x     = {1'b0, len};
  assign win     = meas_ok && (c_x >= d_x) && ((c_x + d_x) < l_x);
  assign fe_win  = meas_ok && (c_x >= d_x) && ((c_x + d_x + ONE_X) < l_x);
  assign ring_ok = $onehot(ring_cur);
  assign ph0_d   = (ring_ok && win) ? ring_cur : '0;
  assign fe_d    = ring_ok && ring_cur[0] && fe_win;

  always_ff @(posedge clk_ref_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph0_q <= '0;
      fe_q  <= 1'b0;
    end else begin
      ph0_q <= ph0_d;
      fe_q  <= fe_d;
    end
  end

  // stage k takes bit (j - k) mod 3 of stage 0
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    for (genvar j = 0; j < PHASES; j++) begin : g_ph
      localparam int SRC = (j + PHASES - (k % PHASES)) % PHASES;
      assign phase_o[PHASES*k + j] = ph0_q[SRC];
    end
  end

  assign fe_phase_o = fe_q;
endmodule

// File: rtl/pgen_checks.sv
module pgen_checks #(
  parameter int DEAD_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DEAD_W-1:0] dead_i,
  input logic [2:0]        ph0_i,
  input logic              fe_i,
  input logic              edge_i,
  input logic              ok_i,
  input logic [2:0]        ring_i
);
  localparam logic [DEAD_W:0] LO_MAX = '1;

  logic [DEAD_W:0] lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            lo_cnt <= LO_MAX;
    else if (ph0_i != '0)   lo_cnt <= '0;
    else if (lo_cnt != LO_MAX) lo_cnt <= lo_cnt + 1'b1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ph0_i)); // R3

  AST_FE_IN_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe_i |-> ph0_i[0]); // R6

  AST_QUIET_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ok_i) |-> (ph0_i == '0 && !fe_i)); // R1

  AST_RESYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && !$onehot(ring_i)) |=> (ring_i == 3'b001)); // R8

  AST_GAP_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph0_i != '0 && ph0_i != $past(ph0_i)) |-> (lo_cnt >= (DEAD_W+1)'(dead_i))); // R9
endmodule

bind nonoverlap_phase_gen pgen_checks #(.DEAD_W(DEAD_W)) u_checks (
  .clk_i (clk_ref_i),
  .rst_ni(rst_ni),
  .dead_i(dead_i),
  .ph0_i (phase_o[2:0]),
  .fe_i  (fe_phase_o),
  .edge_i(in_edge),
  .ok_i  (meas_ok),
  .ring_i(ring_cur)
);

// File: tb/test_nonoverlap_phase_gen.sv
module test_nonoverlap_phase_gen;
  localparam int STAGES = 3;
  localparam int DW     = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clk_in = 1'b0;
  logic [DW-1:0]     dead = '0;
  logic [3*STAGES-1:0] phase;
  logic              fe;

  int  h_cur = 6;
  int  n_cmp = 0, n_bad = 0;
  bit  done = 0, gap_en = 0, upset_win = 0, upset_pend = 0;
  bit  expect_first = 1;
  string first_tag = "R2";

  always #4 clk = ~clk;

  nonoverlap_phase_gen i_nonoverlap_phase_gen (
    .clk_ref_i(clk), .rst_ni(rst_n), .clk_in_i(clk_in),
    .dead_i(dead), .phase_o(phase), .fe_phase_o(fe)
  );

  initial forever begin
    repeat (h_cur) @(negedge clk);
    clk_in = ~clk_in;
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference: input history, period count, phase index
  int a1, a2, a3, m_cnt, m_len, m_ring;
  bit m_started, m_ok, e_quiet;
  logic [2:0] e_ph0;
  logic e_fe;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a1 = 0; a2 = 0; a3 = 0; m_cnt = 0; m_len = 0; m_ring = 0;
      m_started = 0; m_ok = 0; e_quiet = 1; e_ph0 = 3'b0; e_fe = 1'b0;
    end else begin
      bit rise, win, fwin;
      int d;
      if (upset_pend) begin m_ring = -1; upset_pend = 0; end
      d    = int'(dead);
      rise = (a2 == 1) && (a3 == 0);
      win  = m_ok && (m_cnt >= d) && (m_cnt + d < m_len);
      fwin = m_ok && (m_cnt >= d) && (m_cnt + d + 1 < m_len);
      e_quiet = !m_ok;
      e_ph0 = (m_ring >= 0 && win) ? 3'(1 << m_ring) : 3'b0;
      e_fe  = (m_ring == 0) && fwin;
      if (rise) begin
        if (m_ring < 0) m_ring = 0;
        else if (m_ok)  m_ring = (m_ring + 1) % 3;
        if (m_started) begin
          m_ok  = 1;
          m_len = (m_cnt >= 255) ? 255 : m_cnt + 1;
        end
        m_started = 1;
        m_cnt = 0;
      end else begin
        m_cnt = (m_cnt >= 255) ? 255 : m_cnt + 1;
      end
      a3 = a2; a2 = a1; a1 = int'(clk_in);
    end
  end

  // per-cycle comparison and phase-sequence tracking
  logic [2:0] prev_ph0;
  int last_idx, last_s0, lo_run, hi_run, cyc;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ph0 = 3'b0; last_idx = -1; last_s0 = -1;
      lo_run = 0; hi_run = 0; cyc = 0;
    end else begin
      logic [3*STAGES-1:0] exp_v;
      logic [2:0] ph0;
      int idx;
      string tag;
      for (int k = 0; k < STAGES; k++)
        for (int j = 0; j < 3; j++)
          exp_v[3*k+j] = e_ph0[(j + 3 - (k % 3)) % 3];
      n_cmp++;
      if (phase !== exp_v || fe !== e_fe) begin
        n_bad++;
        if (e_quiet)                  tag = "R1";
        else if (upset_win)           tag = "R8";
        else if (phase[2:0] !== e_ph0) tag = "R5";
        else if (fe !== e_fe)         tag = "R6";
        else                          tag = "R7";
        $display("FAIL %s: phase=%b fe=%b expected phase=%b fe=%b",
                 tag, phase, fe, exp_v, e_fe);
      end
      ph0 = phase[2:0];
      check($onehot0(ph0), "R3", "active stage-0 phases", $countones(ph0), 1);
      if (!gap_en) last_s0 = -1;
      if (ph0 !== prev_ph0) begin
        if (prev_ph0 != 3'b0 && gap_en)
          check(hi_run == 2*h_cur - 2*int'(dead), "R4", "phase high width",
                hi_run, 2*h_cur - 2*int'(dead));
        if (ph0 != 3'b0) begin
          idx = ph0[0] ? 0 : (ph0[1] ? 1 : 2);
          check(((prev_ph0 == 3'b0) ? lo_run : 0) >= int'(dead), "R9", "low gap",
                (prev_ph0 == 3'b0) ? lo_run : 0, int'(dead));
          if (expect_first) begin
            check(idx == 0, first_tag, "first phase index", idx, 0);
            expect_first = 0;
          end else if (last_idx >= 0) begin
            check(idx == (last_idx + 1) % 3, "R2", "phase order", idx, (last_idx + 1) % 3);
          end
          if (gap_en && last_idx >= 0)
            check(((prev_ph0 == 3'b0) ? lo_run : 0) == 2*int'(dead), "R4", "gap width",
                  (prev_ph0 == 3'b0) ? lo_run : 0, 2*int'(dead));
          if (idx == 0) begin
            if (gap_en && last_s0 >= 0)
              check(cyc - last_s0 == 6*h_cur, "R2", "sample repeat", cyc - last_s0, 6*h_cur);
            last_s0 = cyc;
          end
          last_idx = idx;
        end
        hi_run = (ph0 != 3'b0) ? 1 : 0;
        lo_run = (ph0 == 3'b0) ? 1 : 0;
      end else begin
        if (ph0 != 3'b0) hi_run++;
        else             lo_run++;
      end
      prev_ph0 = ph0;
      cyc++;
    end
  end

  task automatic run_cfg(int d, int h, int frames);
    gap_en = 0;
    rst_n = 0;
    dead = DW'(d);
    h_cur = h;
    expect_first = 1;
    first_tag = "R2";
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(phase == '0 && fe == 1'b0, "R1", "outputs right after reset", int'(phase), 0);
    repeat (h - 2) @(negedge clk);
    check(phase == '0 && fe == 1'b0, "R1", "outputs before full period", int'(phase), 0);
    repeat (6*h*2) @(negedge clk);
    gap_en = 1;
    repeat (6*h*frames) @(negedge clk);
    gap_en = 0;
  endtask

  initial begin
    run_cfg(1, 6, 6);
    run_cfg(2, 8, 6);
    run_cfg(0, 4, 6);
    run_cfg(3, 10, 4);
    // shorter input period while running
    h_cur = 7;
    repeat (6*7*3) @(negedge clk);
    gap_en = 1;
    repeat (6*7*4) @(negedge clk);
    // ring upset in the middle of a sample window
    do @(negedge clk); while (fe !== 1'b1);
    gap_en = 0;
    upset_win = 1;
    upset_pend = 1;
    force i_nonoverlap_phase_gen.u_ring.ring_q = 3'b011;
    @(negedge clk);
    release i_nonoverlap_phase_gen.u_ring.ring_q;
    first_tag = "R8";
    expect_first = 1;
    last_idx = -1;
    repeat (6*7*2) @(negedge clk);
    check(expect_first == 0, "R8", "restart seen", int'(expect_first), 0);
    upset_win = 0;
    gap_en = 1;
    repeat (6*7*3) @(negedge clk);
    gap_en = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog: run still going, expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule